// File: doc/BRIEF.md
# DRAM Access Sequencer

This block sits between a CPU-side request port and an external DRAM. Each request carries an address and a read/write flag. The block first decides whether the address lies in one of the address areas that can hold DRAM. It then drives the row and column halves of the address onto a shared address bus, framed by active-low RAS, CAS and write-enable strobes. A single-cycle response pulse marks the end of each access.

A one-byte configuration register selects four behaviours:
- **Precharge length:** one or two precharge states before a row is opened.
- **Page bursting:** whether a following access to the row that is already open skips RAS and issues only a new CAS.
- **RAS hold:** whether RAS is released after every access or kept low while the sequencer waits.
- **Row shift:** how far the address is shifted to form the row. The same shift also sets which bits are compared to detect a page hit.

Requests use a valid/ready handshake. The block holds `req_ready` high only while it is idle, and a request is taken on a cycle where both `req_valid` and `req_ready` are high. The response side has no back-pressure: `resp_valid` is a one-cycle pulse that the requester must take when it appears. The address and write flag only need to be stable in the accepting cycle.

Top module: `dram_seq`

## Requirements
- R1: After reset, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `resp_valid` is low, `req_ready` is high and `cfg_rdata` reads 0x00.
- R2: An access goes through the DRAM sequence only if `req_addr[23:21]` is 2, 3, 4 or 5 and the matching bit of `area_dram_en` is set (bit index = area − 2). Any other access produces no CAS, leaves RAS released, and raises `resp_valid` one cycle after acceptance.
- R3: A full access runs in this order:
  - the precharge state(s), with RAS high;
  - the row address on `dram_ma`, with RAS low;
  - one cycle later, the column address with CAS low;
  - then CAS high together with a one-cycle `resp_valid`.
  With configuration bit 7 clear, `resp_valid` rises 4 cycles after acceptance.
- R4: Configuration bit 7 set inserts a second precharge state, so a full access responds 5 cycles after acceptance.
- R5: When configuration bit 6 is set, RAS is still low from an earlier access, and the new access hits the same row, only a CAS cycle is issued (no new RAS edge) and `resp_valid` rises 2 cycles after acceptance. When bit 6 is clear, every DRAM access is a full access.
- R6: With configuration bit 5 clear, RAS is high once each access ends and stays high while the sequencer is idle. With bit 5 set, RAS stays low after a DRAM access while the sequencer waits.
- R7: With RAS held low, an access to a different row releases RAS, runs the precharge state(s) and opens the new row. An access to a non-DRAM area releases RAS.
- R8: Configuration bits 3:2 (code k) select a shift of 8+k bits. The row driven on `dram_ma` is `(addr >> (8+k))[11:0]`, the column is `addr[11:0]`, and the page-hit comparison uses the 16 bits `(addr >> (8+k))[15:0]`.
- R9: Configuration bits 4, 1 and 0 always read 0, and writes to them are ignored.
- R10: A configuration write takes effect only while the sequencer is idle with RAS high. A write made at any other time is held, the latest one wins, and it is applied once that condition holds.
- R11: `req_ready` is high only when the sequencer is idle. CAS stays low for exactly one cycle per DRAM access, and `resp_valid` is a single-cycle pulse.
- R12: `dram_we_n` is low during the CAS cycle of a write access and high at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | 24 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| resp_valid | output | 1 | One-cycle completion pulse |
| area_dram_en | input | 4 | Marks areas 2..5 as DRAM (bit 0 = area 2) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Active configuration |
| dram_ma | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |

## Verification
Each result is due at a fixed number of cycles after the accepting edge:
- 1 cycle for a non-DRAM access;
- 2 cycles for a page hit;
- 4 or 5 cycles for a full access, depending on the precharge bit.

When the driver issues a request, it pushes that expected latency, the expected row and column, the write-enable level and the RAS level after the access into a queue. A monitor samples on falling clock edges. It counts the edges since acceptance, records the address at each RAS fall and each CAS cycle, and compares everything against the queue entry when `resp_valid` appears. Configuration writes are checked through `cfg_rdata` a few cycles after the condition for them to take effect has arisen.

// File: rtl/dram_seq_pkg.sv
`timescale 1ns/1ps
package dram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE1, ST_PRE2, ST_ROW, ST_COL, ST_END
  } seq_state_e;

  localparam int unsigned SHIFT_BASE = 8;
  localparam logic [7:0]  CFG_MASK   = 8'hEC;
  localparam int unsigned BIT_PRE2   = 7;
  localparam int unsigned BIT_BURST  = 6;
  localparam int unsigned BIT_HOLD   = 5;
  localparam int unsigned SHIFT_LSB  = 2;
endpackage

// File: rtl/dram_seq_cfg.sv
`timescale 1ns/1ps
module dram_seq_cfg
  import dram_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       quiet,
  output logic [7:0] cfg_q
);
  logic [7:0] pend_q;
  logic       pend_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= 8'h00;
      pend_q   <= 8'h00;
      pend_vld <= 1'b0;
    end else if (quiet) begin
      if (wr_en)         cfg_q <= wr_data & CFG_MASK;
      else if (pend_vld) cfg_q <= pend_q;
      pend_vld <= 1'b0;
    end else if (wr_en) begin
      pend_q   <= wr_data & CFG_MASK;
      pend_vld <= 1'b1;
    end
  end

  AST_CFG_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !quiet |=> $stable(cfg_q)); // R10
endmodule

// File: rtl/dram_seq_decode.sv
`timescale 1ns/1ps
module dram_seq_decode
  import dram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned MA_W       = 12,
  parameter int unsigned NUM_AREAS  = 4,
  parameter int unsigned FIRST_AREA = 2,
  parameter int unsigned AREA_W     = 3,
  localparam int unsigned ROW_W     = ADDR_W - SHIFT_BASE
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_AREAS-1:0] area_en,
  input  logic [1:0]           shift,
  input  logic                 burst,
  input  logic                 row_open,
  input  logic [ROW_W-1:0]     open_row,
  output logic                 is_dram,
  output logic                 page_hit,
  output logic [ROW_W-1:0]     row_key,
  output logic [MA_W-1:0]      row_ma,
  output logic [MA_W-1:0]      col_ma
);
  logic [AREA_W-1:0]    area;
  logic [NUM_AREAS-1:0] area_hit;

  assign area = addr[ADDR_W-1 -: AREA_W];

  for (genvar i = 0; i < NUM_AREAS; i++) begin : g_area
    assign area_hit[i] = area_en[i] && (area == AREA_W'(FIRST_AREA + i));
  end

  assign is_dram  = |area_hit;
  assign row_key  = ROW_W'(addr >> (SHIFT_BASE + 32'(shift)));
  assign row_ma   = row_key[MA_W-1:0];
  assign col_ma   = addr[MA_W-1:0];
  assign page_hit = is_dram && burst && row_open && (row_key == open_row);
endmodule

// File: rtl/dram_seq_fsm.sv
`timescale 1ns/1ps
module dram_seq_fsm
  import dram_seq_pkg::*;
#(
  parameter int unsigned MA_W  = 12,
  parameter int unsigned ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             is_dram,
  input  logic             page_hit,
  input  logic [ROW_W-1:0] row_key,
  input  logic [MA_W-1:0]  row_ma,
  input  logic [MA_W-1:0]  col_ma,
  input  logic             pre2,
  input  logic             ras_hold,
  output logic             req_ready,
  output logic             resp_valid,
  output logic [MA_W-1:0]  ma,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             row_open,
  output logic [ROW_W-1:0] open_row,
  output logic             quiet
);
  seq_state_e       state;
  logic [MA_W-1:0]  row_q, col_q;
  logic [ROW_W-1:0] key_q;
  logic             wr_q;

  assign req_ready = (state == ST_IDLE);
  assign quiet     = (state == ST_IDLE) && ras_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ras_n      <= 1'b1;
      cas_n      <= 1'b1;
      we_n       <= 1'b1;
      resp_valid <= 1'b0;
      ma         <= '0;
      row_open   <= 1'b0;
      open_row   <= '0;
      row_q      <= '0;
      col_q      <= '0;
      key_q      <= '0;
      wr_q       <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          row_q <= row_ma;
          col_q <= col_ma;
          key_q <= row_key;
          wr_q  <= req_write;
          if (!is_dram) begin
            ras_n      <= 1'b1;
            row_open   <= 1'b0;
            resp_valid <= 1'b1;
            state      <= ST_END;
          end else if (page_hit) begin
            ma    <= col_ma;
            cas_n <= 1'b0;
            we_n  <= !req_write;
            state <= ST_COL;
          end else begin
            ras_n    <= 1'b1;
            row_open <= 1'b0;
            state    <= ST_PRE1;
          end
        end
        ST_PRE1: begin
          if (pre2) state <= ST_PRE2;
          else begin
            ma    <= row_q;
            ras_n <= 1'b0;
            state <= ST_ROW;
          end
        end
        ST_PRE2: begin
          ma    <= row_q;
          ras_n <= 1'b0;
          state <= ST_ROW;
        end
        ST_ROW: begin
          ma       <= col_q;
          cas_n    <= 1'b0;
          we_n     <= !wr_q;
          row_open <= 1'b1;
          open_row <= key_q;
          state    <= ST_COL;
        end
        ST_COL: begin
          cas_n      <= 1'b1;
          we_n       <= 1'b1;
          resp_valid <= 1'b1;
          if (!ras_hold) begin
            ras_n    <= 1'b1;
            row_open <= 1'b0;
          end
          state <= ST_END;
        end
        ST_END: begin
          resp_valid <= 1'b0;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n); // R3
  AST_CAS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |=> cas_n); // R11
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid); // R11
  AST_WE_IN_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cas_n); // R12
  AST_RAS_UP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !ras_hold) |-> ras_n); // R6
endmodule

// File: rtl/dram_seq.sv
`timescale 1ns/1ps
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned MA_W      = 12,
  parameter int unsigned NUM_AREAS = 4,
  localparam int unsigned ROW_W    = ADDR_W - SHIFT_BASE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_write,
  output logic                 resp_valid,
  input  logic [NUM_AREAS-1:0] area_dram_en,
  input  logic                 cfg_we,
  input  logic [7:0]           cfg_wdata,
  output logic [7:0]           cfg_rdata,
  output logic [MA_W-1:0]      dram_ma,
  output logic                 dram_ras_n,
  output logic                 dram_cas_n,
  output logic                 dram_we_n
);
  logic             quiet, is_dram, page_hit, row_open;
  logic [ROW_W-1:0] row_key, open_row;
  logic [MA_W-1:0]  row_ma, col_ma;

  dram_seq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .quiet(quiet), .cfg_q(cfg_rdata)
  );

  dram_seq_decode #(.ADDR_W(ADDR_W), .MA_W(MA_W), .NUM_AREAS(NUM_AREAS)) u_dec (
    .addr(req_addr), .area_en(area_dram_en),
    .shift(cfg_rdata[SHIFT_LSB +: 2]), .burst(cfg_rdata[BIT_BURST]),
    .row_open(row_open), .open_row(open_row), .is_dram(is_dram),
    .page_hit(page_hit), .row_key(row_key), .row_ma(row_ma), .col_ma(col_ma)
  );

  dram_seq_fsm #(.MA_W(MA_W), .ROW_W(ROW_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .is_dram(is_dram), .page_hit(page_hit), .row_key(row_key),
    .row_ma(row_ma), .col_ma(col_ma), .pre2(cfg_rdata[BIT_PRE2]),
    .ras_hold(cfg_rdata[BIT_HOLD]), .req_ready(req_ready),
    .resp_valid(resp_valid), .ma(dram_ma), .ras_n(dram_ras_n),
    .cas_n(dram_cas_n), .we_n(dram_we_n), .row_open(row_open),
    .open_row(open_row), .quiet(quiet)
  );
endmodule

// File: tb/dram_seq_tb.sv
`timescale 1ns/1ps
module dram_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, cfg_we = 1'b0;
  logic [23:0] req_addr = '0;
  logic [3:0]  area_dram_en = 4'b0111;
  logic [7:0]  cfg_wdata = '0;
  logic        req_ready, resp_valid, ras_n, cas_n, we_n;
  logic [7:0]  cfg_rdata;
  logic [11:0] ma;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dram_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .resp_valid(resp_valid),
    .area_dram_en(area_dram_en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .dram_ma(ma), .dram_ras_n(ras_n),
    .dram_cas_n(cas_n), .dram_we_n(we_n)
  );

  typedef struct {
    int          lat;
    bit          opens;
    logic [11:0] row;
    logic [11:0] col;
    int          ncas;
    bit          wr;
    bit          ras_after;
    string       tag;
  } exp_t;
  exp_t q[$];

  // bench model of the configuration and open row
  bit          m_pre2, m_burst, m_hold, m_open;
  int          m_shift;
  logic [15:0] m_key;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_model(logic [7:0] v);
    m_pre2 = v[7]; m_burst = v[6]; m_hold = v[5]; m_shift = int'(v[3:2]);
  endtask

  // monitor: counts edges since acceptance and compares with the queue
  int          cnt = 0, cas_cnt = 0;
  bit          busy = 0, opened = 0, prev_ras = 1;
  logic [11:0] row_seen = '0, col_seen = '0;
  bit          we_seen = 1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) cnt++;
      if (!ras_n && prev_ras) begin opened = 1; row_seen = ma; end
      if (!cas_n) begin cas_cnt++; col_seen = ma; we_seen = we_n; end
      if (resp_valid) begin
        if (q.size() == 0) chk(0, "R11 unexpected response", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(cnt == e.lat, {e.tag, " latency"}, cnt, e.lat);
          chk(opened == e.opens, {e.tag, " RAS opened"}, int'(opened), int'(e.opens));
          if (e.opens) chk(row_seen == e.row, {e.tag, " R8 row"}, int'(row_seen), int'(e.row));
          chk(cas_cnt == e.ncas, {e.tag, " R11 CAS count"}, cas_cnt, e.ncas);
          if (e.ncas == 1) begin
            chk(col_seen == e.col, {e.tag, " R8 column"}, int'(col_seen), int'(e.col));
            chk(we_seen == !e.wr, {e.tag, " R12 we_n"}, int'(we_seen), int'(!e.wr));
          end
          chk(ras_n == e.ras_after, {e.tag, " R6 RAS after"}, int'(ras_n), int'(e.ras_after));
        end
        busy = 0;
      end
      if (req_valid && req_ready) begin
        busy = 1; cnt = 0; cas_cnt = 0; opened = 0;
      end
      prev_ras = ras_n;
    end
  end

  task automatic access(logic [23:0] a, bit wr, string tag);
    exp_t e;
    int area;
    bit dram;
    logic [23:0] sh;
    area = int'(a[23:21]);
    dram = (area >= 2 && area <= 5) ? area_dram_en[area-2] : 1'b0;
    sh = a >> (8 + m_shift);
    e.tag = tag; e.col = a[11:0]; e.row = sh[11:0]; e.wr = wr;
    if (!dram) begin
      e.lat = 1; e.opens = 0; e.ncas = 0; e.ras_after = 1; m_open = 0;
    end else if (m_open && m_burst && sh[15:0] == m_key) begin
      e.lat = 2; e.opens = 0; e.ncas = 1; e.ras_after = 0;
    end else begin
      e.lat = 4 + int'(m_pre2); e.opens = 1; e.ncas = 1;
      e.ras_after = !m_hold; m_open = m_hold; m_key = sh[15:0];
    end
    q.push_back(e);
    do @(posedge clk); while (!req_ready);
    #1 req_valid = 1; req_addr = a; req_write = wr;
    @(posedge clk); #1 req_valid = 0; req_write = 0;
    do @(negedge clk); while (!resp_valid);
    @(posedge clk); #1;
  endtask

  task automatic cfg_write(logic [7:0] v);
    @(posedge clk); #1 cfg_we = 1; cfg_wdata = v;
    @(posedge clk); #1 cfg_we = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    set_model(8'h00); m_open = 0; m_key = '0;
    idle(3); rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_n && we_n, "R1 strobes high", {ras_n, cas_n, we_n}, 3'b111);
    chk(!resp_valid, "R1 resp low", int'(resp_valid), 0);
    chk(req_ready, "R1 ready", int'(req_ready), 1);
    chk(cfg_rdata == 8'h00, "R1 cfg", int'(cfg_rdata), 0);
    // R3 R8 full access, 8-bit shift
    access(24'h412345, 0, "R3 full read area2");
    access(24'h6ABCDE, 1, "R12 full write area3");
    // R2 non-DRAM areas
    access(24'h200000, 0, "R2 area1");
    access(24'hA00010, 1, "R2 area5 disabled");
    // R4 two precharge states
    cfg_write(8'h80); set_model(8'h80); idle(2);
    access(24'h412345, 0, "R4 two precharge");
    // R9 reserved bits
    cfg_write(8'hFF); idle(2);
    chk(cfg_rdata == 8'hEC, "R9 reserved bits", int'(cfg_rdata), 8'hEC);
    cfg_write(8'h60); set_model(8'h60); idle(2);
    chk(cfg_rdata == 8'h60, "R9 readback", int'(cfg_rdata), 8'h60);
    // R6 R5 hold mode and page hits
    access(24'h412345, 0, "R6 open and hold");
    idle(4);
    chk(!ras_n, "R6 RAS low while waiting", int'(ras_n), 0);
    access(24'h412399, 0, "R5 page hit read");
    access(24'h4123AA, 1, "R5 page hit write");
    // R7 row change
    access(24'h413000, 0, "R7 row miss");
    // R10 write held while RAS low
    cfg_write(8'h0C); idle(3);
    chk(cfg_rdata == 8'h60, "R10 write held", int'(cfg_rdata), 8'h60);
    access(24'h200004, 0, "R7 non-DRAM closes row");
    idle(3);
    chk(cfg_rdata == 8'h0C, "R10 write applied", int'(cfg_rdata), 8'h0C);
    set_model(8'h0C);
    // R8 shift 11
    access(24'h412345, 0, "R8 shift11");
    // R5 burst with RAS up: always full
    cfg_write(8'h4C); set_model(8'h4C); idle(2);
    access(24'h412345, 0, "R5 burst ras up a");
    access(24'h412346, 0, "R5 burst ras up b");
    // R8 compare width with shift 9
    cfg_write(8'h64); set_model(8'h64); idle(2);
    access(24'h412345, 0, "R8 shift9 open");
    access(24'h4123FF, 0, "R8 shift9 hit");
    access(24'h412400, 1, "R8 shift9 miss");
    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule